// File: doc/BRIEF.md
# Four-Output PWM Group with Shadowed Duty Reload

This block produces four pulse-width-modulated outputs from one shared counter. The outputs form two pairs, channels 0/1 and 2/3. The counter runs in one of two alignments. In edge-aligned mode it counts up and wraps, so every pulse begins at the start of the period. In center-aligned mode it counts up and then back down, so every pulse is placed symmetrically around the turning point of the counter. In paired mode the second output of each pair is the inverse of the first, and only the duty of the first output is used. In non-paired mode each of the four outputs follows its own duty value.

Software loads all four duty values at once through a write strobe into a shadow bank. The comparators only see an active bank. That active bank is copied from the shadow at the start of each period. In dual-update mode it is also copied at the period midpoint, which lets the two halves of a center-aligned pulse differ. The period value and the three mode bits are captured only at the period start, so a change never cuts a period short. Two output pulses mark the reload points.

Top module: `pwm_group`

## Requirements
- R1: While rst_n is low at a clock edge, and in the first cycle after it, pwm_out is 0000 and load_start and load_mid are both 0.
- R2: In edge-aligned mode (cfg_center=0) with effective period P, the counter steps 0,1,…,P-1 and then wraps, giving a period of P cycles. Output k is high while the counter is below its active duty value. pwm_out is registered, so it reflects the counter and duty of the previous cycle.
- R3: In center-aligned mode (cfg_center=1) the counter steps 0…P-1 and then P-1…0, giving a period of 2P cycles. Output k is high while the counter is at least P minus its duty value, so the pulse is centered on the counter's turning point.
- R4: A duty of 0 keeps an output low for the whole period. A duty of P or more keeps it high for the whole period, in both alignments.
- R5: With cfg_paired=1, pwm_out[1] is the inverse of pwm_out[0] and pwm_out[3] is the inverse of pwm_out[2]. Duty values for channels 1 and 3 are ignored.
- R6: With cfg_paired=0, each of the four outputs follows its own duty field. Channel k's duty is duty_in[k*CNT_W +: CNT_W].
- R7: A duty_wr pulse stores duty_in in the shadow bank only. Outputs change only after a following reload point.
- R8: With cfg_dual_update=0, the active duties are reloaded only at the period start. A shadow write made mid-period has no effect until the next period.
- R9: With cfg_dual_update=1, the active duties are also reloaded at the midpoint. In center mode this is the first down-count cycle (counter P-1). In edge mode it is the cycle where the counter equals P/2, rounded down.
- R10: load_start is high for exactly the first cycle of each period. load_mid is high for exactly the cycle in which a midpoint reload takes effect. Both are the cycles in which the new active duties apply.
- R11: period and the three mode inputs are captured at each period start. The effective period is max(period, 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_center | input | 1 | 1 = center-aligned, 0 = edge-aligned |
| cfg_paired | input | 1 | 1 = complementary pairs |
| cfg_dual_update | input | 1 | 1 = extra reload at midpoint |
| period | input | CNT_W | Period value P (minimum 4 applied) |
| duty_wr | input | 1 | Write strobe for the shadow duty bank |
| duty_in | input | 4*CNT_W | Four duty fields, channel k at bits k*CNT_W |
| pwm_out | output | 4 | Registered PWM outputs |
| load_start | output | 1 | Pulse: period-start reload in effect |
| load_mid | output | 1 | Pulse: midpoint reload in effect |

## Verification
Every result is keyed to the cycle in which load_start goes high; that cycle is period cycle 0. The reload pulses are due in the same cycle that the new duties apply. The output bits are due one cycle later, so the value sampled in period cycle j is computed from the counter and duty of cycle j-1. The bench skips one full period after a configuration change, queues the expected flags and outputs for cycles 1 to the period length, and compares one queued item per falling edge. A shadow write is placed in cycle 2 of the checked period, so both the midpoint reload and its absence in single-update mode are measured inside that same period.

// File: rtl/pwm_group_pkg.sv
// Shared definitions for the PWM group: channel counts and the mode bundle.
package pwm_group_pkg;
    localparam int NCH   = 4;
    localparam int NPAIR = NCH / 2;

    // Mode bits captured together at every period start
    typedef struct packed {
        logic center;
        logic paired;
        logic dual;
    } pwm_cfg_t;
endpackage

// File: rtl/pwm_timebase.sv
// Shared period counter. Edge mode counts 0..P-1 and wraps; center mode counts
// 0..P-1 then P-1..0. It captures period and mode at each period start and flags
// the cycle before a period start and the cycle before the midpoint.
// Assumes the clamped period is at least MIN_PERIOD, which is at least 4.
module pwm_timebase
    import pwm_group_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int MIN_PERIOD = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_in,
    input  pwm_cfg_t         cfg_in,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] per_act,
    output pwm_cfg_t         cfg_act,
    output logic             start_evt,
    output logic             mid_evt
);
    localparam logic [CNT_W-1:0] PMIN = CNT_W'(MIN_PERIOD);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic             up;
    logic [CNT_W-1:0] per_clamped;
    logic [CNT_W-1:0] last;
    logic [CNT_W-1:0] half_m1;

    // Apply the minimum period to the requested value
    always_comb per_clamped = (period_in < PMIN) ? PMIN : period_in;

    assign last    = per_act - ONE;
    assign half_m1 = (per_act >> 1) - ONE;

    // Detect the last cycle of a period and the cycle before the midpoint
    always_comb begin
        if (cfg_act.center) begin
            start_evt = !up && (cnt == '0);
            mid_evt   = up && (cnt == last);
        end else begin
            start_evt = (cnt == last);
            mid_evt   = (cnt == half_m1);
        end
    end

    // Advance the counter and capture settings at each period start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            up      <= 1'b1;
            per_act <= per_clamped;
            cfg_act <= cfg_in;
        end else if (start_evt) begin
            cnt     <= '0;
            up      <= 1'b1;
            per_act <= per_clamped;
            cfg_act <= cfg_in;
        end else if (cfg_act.center) begin
            if (up) begin
                if (cnt == last) up <= 1'b0;
                else             cnt <= cnt + ONE;
            end else begin
                cnt <= cnt - ONE;
            end
        end else begin
            cnt <= cnt + ONE;
        end
    end
endmodule

// File: rtl/pwm_duty_bank.sv
// Shadow and active duty registers. A write strobe fills the shadow bank.
// A load strobe copies the whole shadow bank into the active bank.
// Assumes the write and load strobes are single-cycle and synchronous to clk.
module pwm_duty_bank
    import pwm_group_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [NCH*CNT_W-1:0] duty_in,
    input  logic                 load_en,
    output logic [CNT_W-1:0]     duty_act [NCH]
);
    logic [CNT_W-1:0] shadow [NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // Hold the written value, and copy it to the active bank on reload
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow[i]   <= '0;
                duty_act[i] <= '0;
            end else begin
                if (wr_en)   shadow[i]   <= duty_in[i*CNT_W +: CNT_W];
                if (load_en) duty_act[i] <= shadow[i];
            end
        end
    end
endmodule

// File: rtl/pwm_chan_cmp.sv
// One channel comparator, with no state. Edge mode: high while cnt < duty.
// Center mode: high while cnt >= P - duty, with the threshold saturating at 0.
// Assumes cnt < per, as the timebase guarantees.
module pwm_chan_cmp #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] per,
    input  logic [CNT_W-1:0] duty,
    input  logic             center,
    output logic             hi
);
    logic [CNT_W-1:0] thr;

    // Compute the center-mode threshold and choose the compare for the alignment
    always_comb begin
        thr = (duty >= per) ? '0 : (per - duty);
        hi  = center ? (cnt >= thr) : (cnt < duty);
    end
endmodule

// File: rtl/pwm_group.sv
// Top of the four-output PWM group. It connects the timebase, the duty bank
// and four comparators, applies pair shaping, and registers the outputs and
// the reload pulses. Assumes duty_wr is a single-cycle strobe.
module pwm_group
    import pwm_group_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int MIN_PERIOD = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_center,
    input  logic                 cfg_paired,
    input  logic                 cfg_dual_update,
    input  logic [CNT_W-1:0]     period,
    input  logic                 duty_wr,
    input  logic [NCH*CNT_W-1:0] duty_in,
    output logic [NCH-1:0]       pwm_out,
    output logic                 load_start,
    output logic                 load_mid
);
    pwm_cfg_t         cfg_in;
    pwm_cfg_t         cfg_act;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] per_act;
    logic             start_evt;
    logic             mid_evt;
    logic             mid_load;
    logic             load_any;
    logic [CNT_W-1:0] duty_act [NCH];
    logic [NCH-1:0]   hi;
    logic [NCH-1:0]   shaped;

    assign cfg_in   = '{center: cfg_center, paired: cfg_paired, dual: cfg_dual_update};
    assign mid_load = mid_evt & cfg_act.dual & ~start_evt;
    assign load_any = start_evt | mid_load;

    pwm_timebase #(.CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .period_in (period),
        .cfg_in    (cfg_in),
        .cnt       (cnt),
        .per_act   (per_act),
        .cfg_act   (cfg_act),
        .start_evt (start_evt),
        .mid_evt   (mid_evt)
    );

    pwm_duty_bank #(.CNT_W(CNT_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (duty_wr),
        .duty_in  (duty_in),
        .load_en  (load_any),
        .duty_act (duty_act)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_cmp
        pwm_chan_cmp #(.CNT_W(CNT_W)) u_cmp (
            .cnt    (cnt),
            .per    (per_act),
            .duty   (duty_act[i]),
            .center (cfg_act.center),
            .hi     (hi[i])
        );
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        assign shaped[2*p]   = hi[2*p];
        assign shaped[2*p+1] = cfg_act.paired ? ~hi[2*p] : hi[2*p+1];
    end

    // Register the shaped outputs and flag the cycles where the new duties apply
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_out    <= '0;
            load_start <= 1'b0;
            load_mid   <= 1'b0;
        end else begin
            pwm_out    <= shaped;
            load_start <= start_evt;
            load_mid   <= mid_load;
        end
    end
endmodule

// File: rtl/pwm_group_chk.sv
// Checker for pwm_group, bound to its internal timebase and duty-bank signals.
// Assumes the synchronous active-low reset of the design it checks.
module pwm_group_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       pwm_out,
    input logic             load_start,
    input logic             load_mid,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] per_act,
    input logic             paired,
    input logic             dual,
    input logic [CNT_W-1:0] duty0
);
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < per_act); // R2

    AST_PAIR_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(paired)) |-> ((pwm_out[1] != pwm_out[0]) && (pwm_out[3] != pwm_out[2]))); // R5

    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(duty0) == '0)) |-> !pwm_out[0]); // R4

    AST_SINGLE_NO_MID: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(dual)) |-> !load_mid); // R8

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        load_start |=> !load_start); // R10

    AST_DUTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !load_start && !load_mid) |-> $stable(duty0)); // R7
endmodule

bind pwm_group pwm_group_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_out    (pwm_out),
    .load_start (load_start),
    .load_mid   (load_mid),
    .cnt        (cnt),
    .per_act    (per_act),
    .paired     (cfg_act.paired),
    .dual       (cfg_act.dual),
    .duty0      (duty_act[0])
);

// File: tb/pwm_group_tb.sv
// Scoreboard bench: a driver queues the expected outputs per cycle and a
// monitor compares them at falling edges.
module pwm_group_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;

    typedef struct {
        logic [5:0] v;
        string      tag;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_center = 1'b0;
    logic           cfg_paired = 1'b0;
    logic           cfg_dual_update = 1'b0;
    logic [W-1:0]   period = W'(10);
    logic           duty_wr = 1'b0;
    logic [4*W-1:0] duty_in = '0;
    logic [3:0]     pwm_out;
    logic           load_start;
    logic           load_mid;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_group #(.CNT_W(W)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_center      (cfg_center),
        .cfg_paired      (cfg_paired),
        .cfg_dual_update (cfg_dual_update),
        .period          (period),
        .duty_wr         (duty_wr),
        .duty_in         (duty_in),
        .pwm_out         (pwm_out),
        .load_start      (load_start),
        .load_mid        (load_mid)
    );

    // Monitor: pop one expected item per cycle and compare
    always @(negedge clk) begin
        exp_t e;
        if (q.size() != 0) begin
            e = q.pop_front();
            n_chk++;
            if ({load_start, load_mid, pwm_out} !== e.v) begin
                n_fail++;
                $display("FAIL %s: got {start,mid,out}=%b expected %b", e.tag,
                         {load_start, load_mid, pwm_out}, e.v);
            end
        end
    end

    task automatic chk(input string tag, input logic [5:0] got, input logic [5:0] expv);
        n_chk++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, expv);
        end
    endtask

    function automatic int cnt_at(input bit center, input int p, input int j);
        if (!center) return j;
        return (j < p) ? j : (2*p - 1 - j);
    endfunction

    function automatic bit hi_of(input bit center, input int p, input int c, input int d);
        if (!center) return c < d;
        return c >= ((d >= p) ? 0 : p - d);
    endfunction

    task automatic write_duty(input int d[4]);
        @(posedge clk); #1;
        duty_wr = 1'b1;
        for (int k = 0; k < 4; k++) duty_in[k*W +: W] = W'(d[k]);
        @(posedge clk); #1;
        duty_wr = 1'b0;
    endtask

    task automatic wait_start();
        do @(negedge clk); while (load_start !== 1'b1);
    endtask

    // Driver: configure, let one period settle, queue expectations for the next one
    task automatic run_case(input string tag, input bit center, input bit paired,
                            input bit dual, input int per_req, input int d1[4], input int d2[4]);
        int p;
        int len;
        int m;
        p   = (per_req < 4) ? 4 : per_req;
        len = center ? 2*p : p;
        m   = center ? p : p/2;
        @(posedge clk); #1;
        cfg_center      = center;
        cfg_paired      = paired;
        cfg_dual_update = dual;
        period          = W'(per_req);
        write_duty(d1);
        wait_start();
        wait_start();
        @(posedge clk); #1;
        for (int j = 1; j <= len; j++) begin
            int   jj;
            int   c;
            int   dk;
            logic [3:0] o;
            exp_t e;
            jj = j - 1;
            c  = cnt_at(center, p, jj);
            for (int k = 0; k < 4; k++) begin
                dk   = (dual && jj >= m) ? d2[k] : d1[k];
                o[k] = hi_of(center, p, c, dk);
            end
            if (paired) begin
                o[1] = ~o[0];
                o[3] = ~o[2];
            end
            e.v   = {(j == len), (dual && j == m), o};
            e.tag = tag;
            q.push_back(e);
        end
        write_duty(d2);
        wait (q.size() == 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 in reset", {load_start, load_mid, pwm_out}, 6'b0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {load_start, load_mid, pwm_out}, 6'b0);

        run_case("R2 R4 R6 edge", 1'b0, 1'b0, 1'b0, 10, '{3, 0, 10, 7}, '{9, 9, 9, 9});
        run_case("R2 R4 R6 R8 edge high duty", 1'b0, 1'b0, 1'b0, 10, '{12, 5, 1, 9}, '{0, 0, 0, 0});
        run_case("R3 R4 R6 center", 1'b1, 1'b0, 1'b0, 8, '{3, 0, 8, 5}, '{1, 1, 1, 1});
        run_case("R3 R5 center paired", 1'b1, 1'b1, 1'b0, 8, '{2, 7, 6, 0}, '{4, 4, 4, 4});
        run_case("R9 R10 center dual", 1'b1, 1'b0, 1'b1, 8, '{2, 4, 6, 1}, '{5, 1, 3, 8});
        run_case("R7 R8 center single", 1'b1, 1'b0, 1'b0, 8, '{2, 4, 6, 1}, '{5, 1, 3, 8});
        run_case("R9 R10 edge dual", 1'b0, 1'b0, 1'b1, 12, '{3, 8, 0, 12}, '{10, 2, 6, 1});
        run_case("R11 R5 edge paired short period", 1'b0, 1'b1, 1'b0, 1, '{1, 0, 3, 0}, '{2, 2, 2, 2});

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule